// File: doc/BRIEF.md
# Two-Tier Short-Circuit Protection Timer

This block decides when a battery pack's discharge switch must be opened because of excess current. It watches two comparator flags taken across a sense resistor. The lower-tier flag marks a moderate overcurrent, nominally 150 mV across the resistor (120 to 180 mV). The higher-tier flag marks a hard short, nominally 375 mV (300 to 450 mV). Each tier has its own blanking timer. The timers advance on a one-microsecond timebase tick, so a brief current spike does not open the switch.

When a tier has been asserted for its whole blanking time, the block requests that the switch open. It records which tier caused the trip and starts a restart wait. Through that wait the request stays on and both flags are ignored. At the end of the wait the switch is closed again and both blanking timers start over. A fault that is still present therefore trips again, which produces a hiccup cycle. The lower-tier blank and the restart wait are both multiples of one shared delay unit, so changing that unit scales them together. By default the lower-tier blank is about 50 ms, the higher-tier blank about 400 µs and the restart wait about 500 ms. A saturating counter records how many trips have occurred.

Top module: `sc_prot_ctrl`

## Requirements
- R1: After the active-low reset, `dsg_off`, `cause_short` and `cause_over` are 0 and `trip_count` is 0.
- R2: While not tripped, a lower-tier flag that is high on LO_BLANK_TICKS consecutive tick cycles (LO_BLANK_TICKS = UNIT_TICKS*LO_MULT), and does not drop in between, raises `dsg_off` at the clock edge of the last of those ticks.
- R3: While not tripped, a higher-tier flag that is high on HI_BLANK_TICKS consecutive tick cycles, without dropping in between, raises `dsg_off` at the clock edge of the last of those ticks.
- R4: A flag that is low in any cycle, with or without a tick, clears that tier's blanking count to zero, and no trip is recorded.
- R5: The cause bits name the tier whose timer expired first: `cause_short`=1 for the higher tier, `cause_over`=1 for the lower tier. If both timers expire on the same tick, only `cause_short` is set.
- R6: After a trip, `dsg_off` and the cause bit stay high for RESTART_TICKS ticks (RESTART_TICKS = UNIT_TICKS*RESTART_MULT), and both flags are ignored. At the clock edge of the last of those ticks, `dsg_off` and both cause bits drop to 0.
- R7: When the restart wait ends, both blanking timers restart from zero. A fault that is still present trips again after a full blanking time.
- R8: `trip_count` rises by one on each trip and saturates at its all-ones value.
- R9: Cycles without a tick advance neither the blanking timers nor the restart timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1us | input | 1 | One-cycle timebase pulse, one per microsecond |
| oc_lo | input | 1 | Lower-tier overcurrent comparator flag |
| oc_hi | input | 1 | Higher-tier short-circuit comparator flag |
| dsg_off | output | 1 | Request to open the discharge switch |
| cause_short | output | 1 | Current trip was caused by the higher tier |
| cause_over | output | 1 | Current trip was caused by the lower tier |
| trip_count | output | TRIP_CNT_W | Saturating count of trips |

## Verification
Every result of this block is registered exactly once after its stimulus. A trip, a restart release or a counter step appears at the clock edge of the tick cycle that caused it, and a flag drop clears its count at the next edge. The bench applies each cycle's tick and flags just after a falling edge and queues the expected outputs for that cycle. A monitor compares them at the next falling edge, one edge after the update, so each expectation is checked in the cycle where it becomes due. The bench runs with shortened delay parameters and pulses the tick on every other cycle, which also exercises the idle cycles between ticks.

// File: rtl/sc_prot_pkg.sv
// Package: shared types for the short-circuit protection timer.
// Assumes: nothing beyond IEEE 1800-2017.
package sc_prot_pkg;

    // Index of each current tier; the higher tier wins ties.
    typedef enum logic {
        TIER_OVER  = 1'b0,
        TIER_SHORT = 1'b1
    } tier_e;

    // Trip cause as held while the switch is forced off.
    typedef struct packed {
        logic short_hit;
        logic over_hit;
    } cause_t;

endpackage

// File: rtl/sc_blank_timer.sv
// Module: sc_blank_timer
// Counts timebase ticks while one comparator flag stays high. It reports
// expiry on the tick that completes LIMIT ticks. A low flag, a clear request,
// or the expiry itself returns the count to zero.
// Assumes: LIMIT >= 1; tick is a one-cycle pulse.
module sc_blank_timer #(
    parameter int LIMIT = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic flag,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Expiry is seen combinationally on the completing tick.
    always_comb begin
        expire = !clr && flag && tick && (cnt == CW'(LIMIT - 1));
    end

    // Advance on ticks with the flag high; clear otherwise or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || !flag || expire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sc_restart_timer.sv
// Module: sc_restart_timer
// Counts timebase ticks while the switch is held off. It signals done on the
// tick that completes LIMIT ticks.
// Assumes: LIMIT >= 1; run is held high for the whole wait.
module sc_restart_timer #(
    parameter int LIMIT = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Done is flagged on the completing tick of the wait.
    always_comb begin
        done = run && tick && (cnt == CW'(LIMIT - 1));
    end

    // Count ticks while running; clear when idle or when finished.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sc_trip_counter.sv
// Module: sc_trip_counter
// Sticky count of trip events that stops at its all-ones value.
// Assumes: inc is a one-cycle pulse per trip.
module sc_trip_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Increment on each trip unless already saturated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != {W{1'b1}})) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/sc_prot_ctrl.sv
// Module: sc_prot_ctrl (top)
// Two-tier overcurrent protection. Each tier has its own blanking timer. A
// tier that stays high for its blank forces the discharge switch off and
// records the cause. A restart wait then re-enables the switch (hiccup).
// The lower-tier blank and the restart wait share the delay unit UNIT_TICKS.
// Assumes: tick_1us is a one-cycle pulse; flags are already synchronised.
module sc_prot_ctrl
    import sc_prot_pkg::*;
#(
    parameter int UNIT_TICKS     = 50000,
    parameter int LO_MULT        = 1,
    parameter int RESTART_MULT   = 10,
    parameter int HI_BLANK_TICKS = 400,
    parameter int TRIP_CNT_W     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_1us,
    input  logic                  oc_lo,
    input  logic                  oc_hi,
    output logic                  dsg_off,
    output logic                  cause_short,
    output logic                  cause_over,
    output logic [TRIP_CNT_W-1:0] trip_count
);
    localparam int LO_BLANK_TICKS = UNIT_TICKS * LO_MULT;
    localparam int RESTART_TICKS  = UNIT_TICKS * RESTART_MULT;
    localparam int NUM_TIERS      = 2;

    logic                 hold_q;
    cause_t               cause_q;
    logic [NUM_TIERS-1:0] tier_flag;
    logic [NUM_TIERS-1:0] tier_exp;
    logic                 trip;
    logic                 restart_done;

    assign tier_flag[TIER_OVER]  = oc_lo;
    assign tier_flag[TIER_SHORT] = oc_hi;

    // One blanking timer per tier, each with its own limit.
    for (genvar g = 0; g < NUM_TIERS; g++) begin : g_tier
        localparam int LIM = (g == int'(TIER_SHORT)) ? HI_BLANK_TICKS : LO_BLANK_TICKS;
        sc_blank_timer #(.LIMIT(LIM)) u_blank (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (hold_q),
            .tick   (tick_1us),
            .flag   (tier_flag[g]),
            .expire (tier_exp[g])
        );
    end

    sc_restart_timer #(.LIMIT(RESTART_TICKS)) u_restart (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (hold_q),
        .tick  (tick_1us),
        .done  (restart_done)
    );

    // A trip happens when either tier expires while the switch is on.
    always_comb begin
        trip = !hold_q && (|tier_exp);
    end

    // Hold state and cause: set on a trip, cleared when the restart ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= 1'b0;
            cause_q <= '0;
        end else if (trip) begin
            hold_q            <= 1'b1;
            cause_q.short_hit <= tier_exp[TIER_SHORT];
            cause_q.over_hit  <= !tier_exp[TIER_SHORT];
        end else if (restart_done) begin
            hold_q  <= 1'b0;
            cause_q <= '0;
        end
    end

    sc_trip_counter #(.W(TRIP_CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (trip),
        .count (trip_count)
    );

    assign dsg_off     = hold_q;
    assign cause_short = cause_q.short_hit;
    assign cause_over  = cause_q.over_hit;

endmodule

// File: rtl/sc_prot_checker.sv
// Module: sc_prot_checker
// Port-level properties of sc_prot_ctrl, attached with bind below.
// Assumes: sampled on the rising clock edge; reset is active low.
module sc_prot_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_1us,
    input logic             oc_lo,
    input logic             oc_hi,
    input logic             dsg_off,
    input logic             cause_short,
    input logic             cause_over,
    input logic [CNT_W-1:0] trip_count
);
    // R1: first sampled edge after reset shows the idle state.
    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (!dsg_off && !cause_short && !cause_over && trip_count == '0));

    // R2, R3: the switch only opens after a tick with some flag high.
    a_r3_trip_needs_flag_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dsg_off) |-> $past(tick_1us && (oc_lo || oc_hi)));

    // R5: a held trip carries exactly one cause; an idle switch carries none.
    a_r5_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cause_short, cause_over}) == (dsg_off ? 1 : 0));

    // R6, R9: the switch stays off across any cycle without a tick.
    a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (dsg_off && !tick_1us) |=> dsg_off);

    // R8: the count moves only on a new trip.
    a_r8_count_on_trip: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(trip_count) |-> $rose(dsg_off));

    // R8: a saturated count never wraps.
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_count == {CNT_W{1'b1}}) |=> (trip_count == {CNT_W{1'b1}}));

endmodule

bind sc_prot_ctrl sc_prot_checker #(.CNT_W(TRIP_CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_1us    (tick_1us),
    .oc_lo       (oc_lo),
    .oc_hi       (oc_hi),
    .dsg_off     (dsg_off),
    .cause_short (cause_short),
    .cause_over  (cause_over),
    .trip_count  (trip_count)
);

// File: tb/sc_prot_ctrl_tb.sv
// Bench: scoreboard for sc_prot_ctrl with shortened delays. The driver task
// applies one cycle of stimulus, steps a requirement-level model and queues
// the expected outputs. A monitor compares them one falling edge later.
module sc_prot_ctrl_tb_top;
    localparam int UNIT   = 6;
    localparam int LOM    = 1;
    localparam int RSM    = 3;
    localparam int HI_T   = 3;
    localparam int CW     = 3;
    localparam int LO_T   = UNIT * LOM;
    localparam int RS_T   = UNIT * RSM;
    localparam int CMAX   = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_1us = 1'b0;
    logic          oc_lo = 1'b0;
    logic          oc_hi = 1'b0;
    logic          dsg_off, cause_short, cause_over;
    logic [CW-1:0] trip_count;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Expected-value queue: {off, short, over, count} plus a requirement tag.
    logic [CW+2:0] exp_q[$];
    string         tag_q[$];

    // Model state, derived from the requirements.
    int lc = 0, hc = 0, rc = 0, m_cnt = 0;
    bit m_off = 0, m_cs = 0, m_co = 0;

    sc_prot_ctrl #(
        .UNIT_TICKS(UNIT), .LO_MULT(LOM), .RESTART_MULT(RSM),
        .HI_BLANK_TICKS(HI_T), .TRIP_CNT_W(CW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .oc_lo(oc_lo), .oc_hi(oc_hi),
        .dsg_off(dsg_off), .cause_short(cause_short), .cause_over(cause_over),
        .trip_count(trip_count)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Advance the model by one cycle of stimulus.
    task automatic model_step(input bit t, input bit lo, input bit hi);
        bit elo = 0;
        bit ehi = 0;
        if (!m_off) begin
            if (!lo) lc = 0; else if (t) begin if (lc == LO_T - 1) elo = 1; else lc++; end
            if (!hi) hc = 0; else if (t) begin if (hc == HI_T - 1) ehi = 1; else hc++; end
            if (elo || ehi) begin
                m_off = 1; m_cs = ehi; m_co = !ehi;
                lc = 0; hc = 0; rc = 0;
                if (m_cnt < CMAX) m_cnt++;
            end
        end else if (t) begin
            if (rc == RS_T - 1) begin
                m_off = 0; m_cs = 0; m_co = 0; lc = 0; hc = 0; rc = 0;
            end else begin
                rc++;
            end
        end
    endtask

    // Driver: one cycle of stimulus, with the expected outputs queued.
    task automatic cyc(input bit t, input bit lo, input bit hi, input string tag);
        @(negedge clk);
        #1;
        tick_1us = t; oc_lo = lo; oc_hi = hi;
        model_step(t, lo, hi);
        exp_q.push_back({m_off, m_cs, m_co, CW'(m_cnt)});
        tag_q.push_back(tag);
    endtask

    // n ticks, each followed by one idle cycle.
    task automatic ticks(input int n, input bit lo, input bit hi, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, lo, hi, tag);
            cyc(1'b0, lo, hi, tag);
        end
    endtask

    // Monitor: compare each queued expectation one falling edge after it was queued.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [CW+2:0] e;
            string         tg;
            logic [CW+2:0] a;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            a  = {dsg_off, cause_short, cause_over, trip_count};
            n_cmp++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: got off/short/over/cnt=%b expected %b at %0t", tg, a, e, $time);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle state straight after reset.
        n_cmp++;
        if ({dsg_off, cause_short, cause_over, trip_count} !== '0) begin
            n_bad++;
            $display("FAIL R1: got %b expected 0", {dsg_off, cause_short, cause_over, trip_count});
        end
        ticks(4, 0, 0, "R1");
        // R9: flags high with no tick make no progress.
        for (int i = 0; i < 12; i++) cyc(1'b0, 1'b1, 1'b1, "R9");
        cyc(1'b0, 1'b0, 1'b0, "R9");
        // R3: higher tier trip; R6: flags ignored through the wait; R7: re-trip.
        ticks(HI_T, 0, 1, "R3");
        ticks(RS_T, 1, 1, "R6");
        ticks(HI_T, 0, 1, "R7");
        ticks(RS_T, 0, 0, "R6");
        // R4: a one-cycle drop clears the lower-tier count; R2: full blank trips.
        ticks(LO_T - 1, 1, 0, "R4");
        cyc(1'b0, 1'b0, 1'b0, "R4");
        ticks(LO_T - 1, 1, 0, "R4");
        ticks(1, 1, 0, "R2");
        ticks(RS_T, 0, 0, "R6");
        // R5: both tiers expire on the same tick, so the higher tier is named.
        ticks(LO_T - HI_T, 1, 0, "R5");
        ticks(HI_T, 1, 1, "R5");
        ticks(RS_T, 0, 0, "R6");
        // R5: the lower tier expires first.
        ticks(LO_T - 2, 1, 0, "R5");
        ticks(2, 1, 1, "R5");
        ticks(RS_T, 0, 0, "R6");
        // R8: further trips saturate the counter.
        for (int k = 0; k < 4; k++) begin
            ticks(HI_T, 0, 1, "R8");
            ticks(RS_T, 0, 0, "R8");
        end
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule